// File: doc/BRIEF.md
# Read Burst Lane Packer

This block sits between user logic and a memory read path. User logic hands it one read request at a time. A request carries a bank, a row, a starting column and a burst size counted in beats. The block passes the bank and row through unchanged. It steps the column itself, one beat per cycle, and raises a read strobe to the memory side for every column it issues. Each 72-bit beat comes back after a fixed latency. That latency is the sum of three parameters: additive latency, CAS latency and round-trip delay.

As beats return, a beat-valid output stays high for one cycle per beat. The block then packs the beats into wide words. Each beat lands in the lane given by its offset from the starting column. A build parameter chooses the word shape: four lanes (288 bits, the 2x shape) or eight lanes (576 bits, the quarter-rate shape). One cycle after a word is complete, an align strobe fires, and the packed word is presented two cycles after that strobe. Only one burst may be in flight. A request that breaks the size or alignment rules is consumed without effect and sets a sticky error flag.

Top module: `rbp_read_packer`

## Requirements
- R1: A request is legal when the burst size is between 4 and 252 inclusive, the size is a multiple of 4, and the start column is a multiple of 8. A legal request seen with `req_ready_o` high is accepted on that clock edge. In the next cycle `req_ready_o` is low and `mem_rd_o` is high.
- R2: An illegal request seen with `req_ready_o` high is consumed without starting a burst: `mem_rd_o` stays low and `req_ready_o` stays high. `err_o` rises in the next cycle and stays high until reset.
- R3: After acceptance, `mem_rd_o` is high for exactly as many consecutive cycles as the burst size. The first of these is the cycle after acceptance. In issue cycle i, `mem_bank_o` and `mem_row_o` equal the request values, and `mem_col_o` equals the start column plus i, modulo 2^COL_W.
- R4: `rd_valid_o` is high for exactly burst-size consecutive cycles. The first of these comes AL+CL+RTD cycles after the first `mem_rd_o` cycle. In each such cycle, the beat on `mem_beat_i` is captured.
- R5: Captured beat i goes to word i div L, in lane i mod L, at bits [72k+71:72k] where k = i mod L. L is 4 (288-bit word) when WIDE=0 and 8 (576-bit word) when WIDE=1.
- R6: When WIDE=1 and the burst size is not a multiple of 8, a last word with four lanes is still emitted, and lanes 4 to 7 of that word are zero.
- R7: `align_o` pulses once per packed word, in the cycle after that word's last beat is captured. `word_valid_o` and `word_o` follow exactly two cycles later, and `word_valid_o` is high at no other time.
- R8: `req_ready_o` is low from the cycle after acceptance through the last `rd_valid_o` cycle. It is high again in the cycle that follows.
- R9: During reset, `req_ready_o` is 1, and `err_o`, `mem_rd_o`, `rd_valid_o`, `align_o` and `word_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request present |
| req_ready_o | output | 1 | Block can take a request |
| req_bank_i | input | BANK_W | Request bank |
| req_row_i | input | ROW_W | Request row |
| req_col_i | input | COL_W | Request start column |
| req_bsize_i | input | BSZ_W | Burst size in beats |
| err_o | output | 1 | Sticky illegal-request flag |
| mem_rd_o | output | 1 | Column read issued this cycle |
| mem_bank_o | output | BANK_W | Bank of issued read |
| mem_row_o | output | ROW_W | Row of issued read |
| mem_col_o | output | COL_W | Column of issued read |
| mem_beat_i | input | BEAT_W | Beat returned by memory |
| rd_valid_o | output | 1 | Beat captured this cycle |
| align_o | output | 1 | Early strobe, word follows in two cycles |
| word_valid_o | output | 1 | Packed word present |
| word_o | output | BEAT_W*4 or BEAT_W*8 | Packed word |

## Verification
The bench builds two copies side by side, with WIDE=1 and WIDE=0. Both use AL=2, CL=5 and RTD=3, which gives a 10-cycle return latency, and both use the default 10-bit column. Running the two shapes on the same requests shows the lane order for both four and eight lanes. The odd-multiple-of-four sizes produce the zero-padded partial wide word. A burst started near the top of the column range shows the column wrapping.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

   localparam int RBP_MIN_BURST  = 4;
   localparam int RBP_MAX_BURST  = 252;
   localparam int RBP_BURST_STEP = 4;
   localparam int RBP_COL_ALIGN  = 8;
   localparam int RBP_ALIGN_LEAD = 2;

   typedef enum logic {
      RBP_IDLE = 1'b0,
      RBP_RUN  = 1'b1
   } rbp_state_e;

endpackage

// File: rtl/rbp_req_check.sv
module rbp_req_check
   import rbp_pkg::*;
#(
   parameter int BSZ_W   = 8,
   parameter int MIN_BS  = RBP_MIN_BURST,
   parameter int MAX_BS  = RBP_MAX_BURST,
   parameter int STEP    = RBP_BURST_STEP,
   parameter int ALIGN   = RBP_COL_ALIGN,
   localparam int STEP_W  = $clog2(STEP),
   localparam int ALIGN_W = $clog2(ALIGN)
) (
   input  logic [BSZ_W-1:0]   bsize_i,
   input  logic [ALIGN_W-1:0] col_lo_i,
   output logic               legal_o
);

   if ((1 << STEP_W) != STEP) begin : g_bad_step
      $error("rbp_req_check: STEP must be a power of two");
   end
   if ((1 << ALIGN_W) != ALIGN) begin : g_bad_align
      $error("rbp_req_check: ALIGN must be a power of two");
   end
   if (MAX_BS >= (1 << BSZ_W)) begin : g_bad_max
      $error("rbp_req_check: MAX_BS does not fit in BSZ_W");
   end

   logic size_in_range;
   logic size_on_step;
   logic col_aligned;

   assign size_in_range = (bsize_i >= BSZ_W'(MIN_BS)) && (bsize_i <= BSZ_W'(MAX_BS));
   assign size_on_step  = (bsize_i[STEP_W-1:0] == '0);
   assign col_aligned   = (col_lo_i == '0);
   assign legal_o       = size_in_range && size_on_step && col_aligned;

endmodule

// File: rtl/rbp_burst_ctrl.sv
module rbp_burst_ctrl
   import rbp_pkg::*;
#(
   parameter int BANK_W = 3,
   parameter int ROW_W  = 14,
   parameter int COL_W  = 10,
   parameter int BSZ_W  = 8,
   parameter int LAT    = 10,
   parameter int LANE_W = 3,
   localparam int LAT_W = $clog2(LAT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic              req_legal_i,
   input  logic [BANK_W-1:0] req_bank_i,
   input  logic [ROW_W-1:0]  req_row_i,
   input  logic [COL_W-1:0]  req_col_i,
   input  logic [BSZ_W-1:0]  req_bsize_i,
   output logic              req_ready_o,
   output logic              err_o,
   output logic              mem_rd_o,
   output logic [BANK_W-1:0] mem_bank_o,
   output logic [ROW_W-1:0]  mem_row_o,
   output logic [COL_W-1:0]  mem_col_o,
   output logic              cap_o,
   output logic              last_o,
   output logic [LANE_W-1:0] lane_o
);

   if (LAT < 1) begin : g_bad_lat
      $error("rbp_burst_ctrl: total latency must be at least one cycle");
   end
   if (LANE_W > BSZ_W) begin : g_bad_lane
      $error("rbp_burst_ctrl: LANE_W wider than burst counter");
   end

   rbp_state_e        state_q;
   logic [BANK_W-1:0] bank_q;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q;
   logic [BSZ_W-1:0]  bs_q;
   logic [BSZ_W-1:0]  iss_cnt_q;
   logic [BSZ_W-1:0]  cap_cnt_q;
   logic [LAT_W-1:0]  lat_cnt_q;
   logic              err_q;
   logic              take;
   logic              issuing;

   assign req_ready_o = (state_q == RBP_IDLE);
   assign take        = req_valid_i && req_ready_o;
   assign issuing     = (state_q == RBP_RUN) && (iss_cnt_q < bs_q);
   assign cap_o       = (state_q == RBP_RUN) && (lat_cnt_q == '0) && (cap_cnt_q < bs_q);
   assign last_o      = cap_o && (cap_cnt_q == bs_q - BSZ_W'(1));
   assign lane_o      = cap_cnt_q[LANE_W-1:0];

   assign mem_rd_o    = issuing;
   assign mem_bank_o  = bank_q;
   assign mem_row_o   = row_q;
   assign mem_col_o   = col_q + COL_W'(iss_cnt_q);
   assign err_o       = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= RBP_IDLE;
         bank_q    <= '0;
         row_q     <= '0;
         col_q     <= '0;
         bs_q      <= '0;
         iss_cnt_q <= '0;
         cap_cnt_q <= '0;
         lat_cnt_q <= '0;
         err_q     <= 1'b0;
      end else begin
         case (state_q)
            RBP_IDLE: begin
               if (take && req_legal_i) begin
                  state_q   <= RBP_RUN;
                  bank_q    <= req_bank_i;
                  row_q     <= req_row_i;
                  col_q     <= req_col_i;
                  bs_q      <= req_bsize_i;
                  iss_cnt_q <= '0;
                  cap_cnt_q <= '0;
                  lat_cnt_q <= LAT_W'(LAT);
               end else if (take) begin
                  err_q <= 1'b1;
               end
            end
            RBP_RUN: begin
               if (issuing) iss_cnt_q <= iss_cnt_q + BSZ_W'(1);
               if (lat_cnt_q != '0) lat_cnt_q <= lat_cnt_q - LAT_W'(1);
               if (cap_o) cap_cnt_q <= cap_cnt_q + BSZ_W'(1);
               if (last_o) begin
                  state_q   <= RBP_IDLE;
                  iss_cnt_q <= '0;
                  cap_cnt_q <= '0;
               end
            end
            default: state_q <= RBP_IDLE;
         endcase
      end
   end

   a_r1_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_ready_o && req_legal_i) |=> (!req_ready_o && mem_rd_o));

   a_r2_reject_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_ready_o && !req_legal_i) |=> (req_ready_o && !mem_rd_o && err_o));

   a_r2_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

   a_r3_col_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o && $past(mem_rd_o)) |-> (mem_col_o == COL_W'($past(mem_col_o) + COL_W'(1))));

   a_r8_busy_while_issue: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o || cap_o) |-> !req_ready_o);

   a_r8_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> (req_ready_o && !cap_o));

endmodule

// File: rtl/rbp_lane_packer.sv
module rbp_lane_packer
   import rbp_pkg::*;
#(
   parameter int BEAT_W = 72,
   parameter int LANES  = 8,
   localparam int LANE_W = $clog2(LANES),
   localparam int WORD_W = BEAT_W * LANES,
   localparam int STAGES = RBP_ALIGN_LEAD + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic              last_i,
   input  logic [LANE_W-1:0] lane_i,
   input  logic [BEAT_W-1:0] beat_i,
   output logic              align_o,
   output logic              word_valid_o,
   output logic [WORD_W-1:0] word_o
);

   if ((1 << LANE_W) != LANES) begin : g_bad_lanes
      $error("rbp_lane_packer: LANES must be a power of two");
   end

   logic [BEAT_W-1:0] acc_q  [LANES];
   logic [BEAT_W-1:0] acc_nx [LANES];
   logic [WORD_W-1:0] packed_w;
   logic              word_done;
   logic              stg_v_q [STAGES];
   logic [WORD_W-1:0] stg_d_q [STAGES];

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign acc_nx[k] = (cap_i && lane_i == LANE_W'(k)) ? beat_i :
                         (cap_i && lane_i == '0)         ? '0     :
                                                           acc_q[k];
      assign packed_w[k*BEAT_W +: BEAT_W] = acc_nx[k];
   end

   assign word_done = cap_i && ((lane_i == LANE_W'(LANES - 1)) || last_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '{default: '0};
      end else if (cap_i) begin
         acc_q <= acc_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_v_q <= '{default: 1'b0};
         stg_d_q <= '{default: '0};
      end else begin
         stg_v_q[0] <= word_done;
         if (word_done) stg_d_q[0] <= packed_w;
         for (int s = 1; s < STAGES; s++) begin
            stg_v_q[s] <= stg_v_q[s-1];
            stg_d_q[s] <= stg_d_q[s-1];
         end
      end
   end

   assign align_o      = stg_v_q[0];
   assign word_valid_o = stg_v_q[STAGES-1];
   assign word_o       = stg_d_q[STAGES-1];

   a_r7_align_lead: assert property (@(posedge clk) disable iff (!rst_n)
      align_o |-> ##2 word_valid_o);

   a_r4_beats_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_i && lane_i != '0) |-> $past(cap_i));

   a_r7_align_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |=> align_o);

endmodule

// File: rtl/rbp_read_packer.sv
module rbp_read_packer
   import rbp_pkg::*;
#(
   parameter int WIDE   = 1,
   parameter int BEAT_W = 72,
   parameter int BANK_W = 3,
   parameter int ROW_W  = 14,
   parameter int COL_W  = 10,
   parameter int BSZ_W  = 8,
   parameter int AL     = 2,
   parameter int CL     = 5,
   parameter int RTD    = 3,
   localparam int LANES  = (WIDE != 0) ? 8 : 4,
   localparam int LANE_W = $clog2(LANES),
   localparam int WORD_W = BEAT_W * LANES,
   localparam int LAT    = AL + CL + RTD,
   localparam int ALGN_W = $clog2(RBP_COL_ALIGN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic [BANK_W-1:0] req_bank_i,
   input  logic [ROW_W-1:0]  req_row_i,
   input  logic [COL_W-1:0]  req_col_i,
   input  logic [BSZ_W-1:0]  req_bsize_i,
   output logic              err_o,
   output logic              mem_rd_o,
   output logic [BANK_W-1:0] mem_bank_o,
   output logic [ROW_W-1:0]  mem_row_o,
   output logic [COL_W-1:0]  mem_col_o,
   input  logic [BEAT_W-1:0] mem_beat_i,
   output logic              rd_valid_o,
   output logic              align_o,
   output logic              word_valid_o,
   output logic [WORD_W-1:0] word_o
);

   if (WIDE != 0 && WIDE != 1) begin : g_bad_wide
      $error("rbp_read_packer: WIDE must be 0 or 1");
   end
   if (BEAT_W < 1) begin : g_bad_beat
      $error("rbp_read_packer: BEAT_W must be positive");
   end
   if (COL_W < ALGN_W) begin : g_bad_col
      $error("rbp_read_packer: COL_W too narrow for column alignment");
   end
   if (AL < 0 || CL < 1 || RTD < 0) begin : g_bad_timing
      $error("rbp_read_packer: latency parameters out of range");
   end

   logic              legal;
   logic              cap;
   logic              last;
   logic [LANE_W-1:0] lane;

   rbp_req_check #(
      .BSZ_W (BSZ_W)
   ) u_check (
      .bsize_i  (req_bsize_i),
      .col_lo_i (req_col_i[ALGN_W-1:0]),
      .legal_o  (legal)
   );

   rbp_burst_ctrl #(
      .BANK_W (BANK_W),
      .ROW_W  (ROW_W),
      .COL_W  (COL_W),
      .BSZ_W  (BSZ_W),
      .LAT    (LAT),
      .LANE_W (LANE_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid_i (req_valid_i),
      .req_legal_i (legal),
      .req_bank_i  (req_bank_i),
      .req_row_i   (req_row_i),
      .req_col_i   (req_col_i),
      .req_bsize_i (req_bsize_i),
      .req_ready_o (req_ready_o),
      .err_o       (err_o),
      .mem_rd_o    (mem_rd_o),
      .mem_bank_o  (mem_bank_o),
      .mem_row_o   (mem_row_o),
      .mem_col_o   (mem_col_o),
      .cap_o       (cap),
      .last_o      (last),
      .lane_o      (lane)
   );

   rbp_lane_packer #(
      .BEAT_W (BEAT_W),
      .LANES  (LANES)
   ) u_pack (
      .clk          (clk),
      .rst_n        (rst_n),
      .cap_i        (cap),
      .last_i       (last),
      .lane_i       (lane),
      .beat_i       (mem_beat_i),
      .align_o      (align_o),
      .word_valid_o (word_valid_o),
      .word_o       (word_o)
   );

   assign rd_valid_o = cap;

endmodule

// File: tb/rbp_read_packer_tb_top.sv
`timescale 1ns/100ps

package rbp_tb_pkg;
   function automatic logic [71:0] beat_of(logic [2:0] b, logic [13:0] r, logic [9:0] c);
      return {c[7:0] ^ 8'hC3, 2'b01, b, r, 1'b0, c, 16'(c * 73 + r), b, r, 1'b1};
   endfunction
endpackage

module rbp_tb_mem #(parameter int LAT = 10) (
   input  logic        clk,
   input  logic        rd,
   input  logic [2:0]  bank,
   input  logic [13:0] row,
   input  logic [9:0]  col,
   output logic [71:0] beat
);
   bit        pv [LAT];
   bit [26:0] pa [LAT];
   always @(posedge clk) begin
      pv[0] <= rd;
      pa[0] <= {bank, row, col};
      for (int k = 1; k < LAT; k++) begin
         pv[k] <= pv[k-1];
         pa[k] <= pa[k-1];
      end
   end
   assign beat = pv[LAT-1] ? rbp_tb_pkg::beat_of(pa[LAT-1][26:24], pa[LAT-1][23:10], pa[LAT-1][9:0]) : '0;
endmodule

module rbp_read_packer_tb_top;
   localparam int AL = 2, CL = 5, RTD = 3;
   localparam int LAT = AL + CL + RTD;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        req_valid = 1'b0;
   logic [2:0]  req_bank = '0;
   logic [13:0] req_row = '0;
   logic [9:0]  req_col = '0;
   logic [7:0]  req_bsize = '0;

   logic rdy8, err8, rd8, dv8, al8, wv8;
   logic [2:0] bk8; logic [13:0] rw8; logic [9:0] cl8;
   logic [71:0] beat8; logic [575:0] w8;
   logic rdy4, err4, rd4, dv4, al4, wv4;
   logic [2:0] bk4; logic [13:0] rw4; logic [9:0] cl4;
   logic [71:0] beat4; logic [287:0] w4;

   rbp_read_packer #(.WIDE(1), .AL(AL), .CL(CL), .RTD(RTD)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(rdy8),
      .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col), .req_bsize_i(req_bsize),
      .err_o(err8), .mem_rd_o(rd8), .mem_bank_o(bk8), .mem_row_o(rw8), .mem_col_o(cl8),
      .mem_beat_i(beat8), .rd_valid_o(dv8), .align_o(al8), .word_valid_o(wv8), .word_o(w8));

   rbp_read_packer #(.WIDE(0), .AL(AL), .CL(CL), .RTD(RTD)) dut_n_i (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(rdy4),
      .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col), .req_bsize_i(req_bsize),
      .err_o(err4), .mem_rd_o(rd4), .mem_bank_o(bk4), .mem_row_o(rw4), .mem_col_o(cl4),
      .mem_beat_i(beat4), .rd_valid_o(dv4), .align_o(al4), .word_valid_o(wv4), .word_o(w4));

   rbp_tb_mem #(.LAT(LAT)) mem8_i (.clk(clk), .rd(rd8), .bank(bk8), .row(rw8), .col(cl8), .beat(beat8));
   rbp_tb_mem #(.LAT(LAT)) mem4_i (.clk(clk), .rd(rd4), .bank(bk4), .row(rw4), .col(cl4), .beat(beat4));

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int nvec = 0, nerr = 0;
   int free_cyc = 0;
   int err_cyc = -1;
   bit done = 1'b0;

   bit [26:0]    exp_rd   [int];
   bit           exp_busy [int];
   bit           exp_dv   [int];
   bit           exp_al4  [int];
   bit           exp_al8  [int];
   logic [575:0] exp_w4   [int];
   logic [575:0] exp_w8   [int];

   task automatic chk(bit ok, string rq, logic [575:0] act, logic [575:0] exp);
      nvec++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s cycle %0d: actual %h expected %h", rq, cyc, act, exp);
      end
   endtask

   task automatic cmp(bit wide, logic rdy, logic rd, logic [26:0] addr, logic dv,
                      logic al, logic wv, logic [575:0] w, logic err);
      bit busy = exp_busy.exists(cyc);
      bit erd  = exp_rd.exists(cyc);
      bit edv  = exp_dv.exists(cyc);
      bit eal  = wide ? exp_al8.exists(cyc) : exp_al4.exists(cyc);
      bit ewv  = wide ? exp_w8.exists(cyc) : exp_w4.exists(cyc);
      bit eerr = (err_cyc >= 0) && (cyc >= err_cyc);
      chk(rdy === !busy, wide ? "R8 wide ready" : "R8 narrow ready", 576'(rdy), 576'(!busy));
      chk(rd === erd, "R1 R3 mem_rd", 576'(rd), 576'(erd));
      if (erd) chk(addr === exp_rd[cyc], "R3 bank/row/col", 576'(addr), 576'(exp_rd[cyc]));
      chk(dv === edv, "R4 rd_valid", 576'(dv), 576'(edv));
      chk(al === eal, "R7 align", 576'(al), 576'(eal));
      chk(wv === ewv, "R7 word_valid", 576'(wv), 576'(ewv));
      if (ewv) begin
         logic [575:0] ew = wide ? exp_w8[cyc] : exp_w4[cyc];
         chk(w === ew, wide ? "R5 R6 wide word" : "R5 narrow word", w, ew);
      end
      chk(err === eerr, "R2 err", 576'(err), 576'(eerr));
   endtask

   task automatic schedule(int a, int b, int r, int c, int bs);
      for (int i = 0; i < bs; i++) begin
         exp_rd[a + 1 + i]     = {3'(b), 14'(r), 10'(c + i)};
         exp_dv[a + 1 + LAT + i] = 1'b1;
      end
      for (int t = a + 1; t <= a + LAT + bs; t++) exp_busy[t] = 1'b1;
      for (int L = 4; L <= 8; L += 4) begin
         for (int w = 0; w * L < bs; w++) begin
            logic [575:0] wd;
            int last, cc;
            wd = '0;
            for (int k = 0; k < L; k++)
               if (w * L + k < bs)
                  wd[k*72 +: 72] = rbp_tb_pkg::beat_of(3'(b), 14'(r), 10'(c + w * L + k));
            last = (w * L + L - 1 < bs) ? w * L + L - 1 : bs - 1;
            cc = a + 1 + LAT + last;
            if (L == 4) begin exp_al4[cc + 1] = 1'b1; exp_w4[cc + 3] = wd; end
            else        begin exp_al8[cc + 1] = 1'b1; exp_w8[cc + 3] = wd; end
         end
      end
   endtask

   task automatic send(int b, int r, int c, int bs);
      int a;
      bit legal;
      @(negedge clk);
      req_valid = 1'b1;
      req_bank  = 3'(b);
      req_row   = 14'(r);
      req_col   = 10'(c);
      req_bsize = 8'(bs);
      while (cyc < free_cyc) @(negedge clk);
      a = cyc;
      legal = (bs >= 4) && (bs <= 252) && (bs % 4 == 0) && (c % 8 == 0);
      if (legal) begin
         schedule(a, b, r, c, bs);
         free_cyc = a + LAT + bs + 1;
      end else begin
         if (err_cyc < 0) err_cyc = a + 1;
         free_cyc = a + 1;
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         chk(rdy8 && rdy4, "R9 reset ready", 576'({rdy8, rdy4}), 576'(2'b11));
         chk(!(err8 || err4 || rd8 || rd4 || dv8 || dv4), "R9 reset err/rd/dv", 576'({err8, err4, rd8, rd4, dv8, dv4}), 576'(0));
         chk(!(al8 || al4 || wv8 || wv4), "R9 reset align/word", 576'({al8, al4, wv8, wv4}), 576'(0));
      end else if (!done) begin
         cmp(1'b1, rdy8, rd8, {bk8, rw8, cl8}, dv8, al8, wv8, w8, err8);
         cmp(1'b0, rdy4, rd4, {bk4, rw4, cl4}, dv4, al4, wv4, 576'(w4), err4);
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      free_cyc = cyc + 1;
      send(1, 100, 0, 8);        // R1 R5 full word, both shapes
      send(2, 200, 16, 4);       // R6 partial wide word, R8 back-pressure
      send(3, 300, 24, 12);      // R5 R6 full + partial
      send(0, 0, 4, 8);          // R2 misaligned column
      send(0, 0, 0, 6);          // R2 size not multiple of 4
      send(0, 0, 0, 0);          // R2 size below minimum
      send(0, 0, 0, 255);        // R2 size above maximum
      send(5, 5000, 512, 252);   // R4 maximum burst
      send(7, 16383, 1016, 16);  // R3 column wrap
      send(4, 7, 8, 4);          // R1 minimum burst after error
      while (cyc < free_cyc + LAT + 8) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nerr++;
         $display("FAIL watchdog: actual cycle %0d expected completion before 20000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end
endmodule